// File: doc/BRIEF.md
# Memory Version Tag Checker

This block sits between a load/store unit and a small data memory and guards every access with a 4-bit version tag. Memory is split into fixed 64-byte blocks, and the checker holds one tag for each block. Every access carries a tag in the top four bits of its 64-bit virtual address. When checking is active for the access, that tag is compared with the tag stored for the block the access touches. A mismatch raises a trap. A store that misses can be reported precisely or as a deferred error, while a load that misses is always reported precisely.

Software writes tags with a tag-set request, one block per request. A block-initialising store wipes the block's tag back to zero. Checking applies only when the task-wide enable and the page's check bit are both set. The tag values 0x0 and 0xF act as wildcards. Loads marked non-faulting are never checked. A tag-set made while the task-wide enable is off raises a disabled-feature trap. A tag-set aimed at a read-only page is refused.

Each request gets a registered response one cycle later. The response carries a grant bit and, if needed, a one-cycle trap pulse. The trap type code and the trap address stay on the outputs until the next trap replaces them. A deferred store error stays latched, together with the PC of the first store that missed, until software clears it.

Top module: `mem_tag_guard`

## Requirements
- R1: The access tag is address bits 63:60 and the block index is address bits 11:6, so one block is 64 bytes. A tag-set writes `req_tag` into that one block only, whatever the offset bits 5:0 are.
- R2: A load or store is compared only when `task_en`=1 and `page_chk`=1. In every other case it is granted with no trap.
- R3: If either the address tag or the stored tag is 0x0 or 0xF, the access never mismatches.
- R4: A store that mismatches while `precise_en`=1 is denied. It raises a trap with code 0x1A, and `trap_addr` is the data address.
- R5: A store that mismatches while `precise_en`=0 is still granted. If no deferred error is latched, or `clr_disrupt` is high in the same cycle, it raises a trap with code 0x7E and `trap_addr` set to `req_pc`, sets `disrupt_pending` and stores the PC in `disrupt_pc`. While the error stays latched and is not cleared, further store mismatches raise no trap and leave `disrupt_pc` unchanged. `clr_disrupt` drops `disrupt_pending`.
- R6: A load that mismatches is always denied with a trap of code 0x1A carrying the data address, whatever `precise_en` is.
- R7: A load with `req_nofault`=1 is never checked. It is granted with no trap.
- R8: A tag-set made while `task_en`=0 is denied. It raises a trap with code 0x0A carrying the data address, and no tag is written.
- R9: A block-initialising store is granted with no trap and sets the block's tag to 0x0.
- R10: A tag-set made while `task_en`=1 and `page_ro`=1 is denied with no trap, and no tag is written.
- R11: Reset, which is synchronous and active high, sets every stored tag to 0x0 and clears every output.
- R12: `req_op` is encoded as 0 load, 1 store, 2 tag-set and 3 block-initialising store. The response appears on the cycle after the request: `rsp_valid` is the request's valid bit delayed by one cycle. `trap_valid` is a pulse lasting one cycle. `trap_code` and `trap_addr` hold their values until the next trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 0 load, 1 store, 2 tag-set, 3 block-initialising store |
| req_nofault | input | 1 | Load is non-faulting |
| req_addr | input | 64 | Virtual address, tag in top bits |
| req_pc | input | 64 | PC of the requesting instruction |
| req_tag | input | 4 | Tag value for a tag-set |
| task_en | input | 1 | Task-wide tag checking enable |
| page_chk | input | 1 | Page check-enable bit from the translation entry |
| page_ro | input | 1 | Page is read-only |
| precise_en | input | 1 | Report store mismatches precisely |
| clr_disrupt | input | 1 | Clear the latched deferred error |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ok | output | 1 | Access granted |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_code | output | 8 | Trap type code (0x1A, 0x7E, 0x0A), held |
| trap_addr | output | 64 | Faulting address or PC, held |
| disrupt_pending | output | 1 | Deferred store error latched |
| disrupt_pc | output | 64 | PC of the first store that missed |

## Verification
The bench aims at the wildcard values on each side of the comparison, because a design that checks only the stored tag would trap on address tag 0xF. It sends a second deferred mismatch while the first is still latched. A design that overwrote the error would report the wrong PC or give a second pulse. It also sends a clear in the same cycle as a new deferred mismatch, which a design with the wrong priority would drop. Refused and disabled tag-sets, and the neighbours of a block that was just tagged, are probed afterwards with mismatching loads. This exposes a design that writes the tag anyway or decodes the block index at the wrong bit position.

// File: rtl/tag_pkg.sv
package tag_pkg;

  typedef enum logic [1:0] {
    OP_LOAD    = 2'd0,
    OP_STORE   = 2'd1,
    OP_TAGSET  = 2'd2,
    OP_BLKINIT = 2'd3
  } op_e;

  localparam logic [7:0] CODE_PRECISE = 8'h1A;
  localparam logic [7:0] CODE_DISRUPT = 8'h7E;
  localparam logic [7:0] CODE_NOTAG   = 8'h0A;

  typedef struct packed {
    logic       ok;
    logic       trap;
    logic [7:0] code;
    logic       sel_pc;
    logic       set_pend;
    logic       wr_en;
    logic       wr_zero;
  } verdict_t;

endpackage

// File: rtl/tag_store.sv
module tag_store #(
  parameter int NUM_BLOCKS = 64,
  parameter int TAG_W      = 4,
  localparam int IDX_W     = $clog2(NUM_BLOCKS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [TAG_W-1:0] mem [NUM_BLOCKS];

  // Reset wipes every block so all of memory starts as a wildcard.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_BLOCKS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_tag;
    end
  end

  assign rd_tag = mem[rd_idx];

endmodule

// File: rtl/tag_judge.sv
module tag_judge
  import tag_pkg::*;
#(
  parameter int TAG_W = 4
) (
  input  logic             valid,
  input  op_e              op,
  input  logic             nofault,
  input  logic             task_en,
  input  logic             page_chk,
  input  logic             page_ro,
  input  logic             precise_en,
  input  logic             pend_now,
  input  logic             clr,
  input  logic [TAG_W-1:0] addr_tag,
  input  logic [TAG_W-1:0] mem_tag,
  output verdict_t         v
);

  localparam logic [TAG_W-1:0] WILD_HI = {TAG_W{1'b1}};

  logic wild;
  logic mism;

  always_comb begin
    wild = (addr_tag == '0) || (addr_tag == WILD_HI) ||
           (mem_tag == '0)  || (mem_tag == WILD_HI);
    mism = task_en && page_chk && !wild && (addr_tag != mem_tag);
  end

  always_comb begin
    v = '0;
    if (valid) begin
      unique case (op)
        OP_LOAD: begin
          if (mism && !nofault) begin
            v.trap = 1'b1;
            v.code = CODE_PRECISE;
          end else begin
            v.ok = 1'b1;
          end
        end
        OP_STORE: begin
          if (mism && precise_en) begin
            v.trap = 1'b1;
            v.code = CODE_PRECISE;
          end else begin
            v.ok = 1'b1;
            // deferred error keeps only the first miss until cleared
            if (mism && (!pend_now || clr)) begin
              v.trap     = 1'b1;
              v.code     = CODE_DISRUPT;
              v.sel_pc   = 1'b1;
              v.set_pend = 1'b1;
            end
          end
        end
        OP_TAGSET: begin
          if (!task_en) begin
            v.trap = 1'b1;
            v.code = CODE_NOTAG;
          end else if (!page_ro) begin
            v.ok    = 1'b1;
            v.wr_en = 1'b1;
          end
        end
        OP_BLKINIT: begin
          v.ok      = 1'b1;
          v.wr_en   = 1'b1;
          v.wr_zero = 1'b1;
        end
        default: v = '0;
      endcase
    end
  end

endmodule

// File: rtl/trap_report.sv
module trap_report
  import tag_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  verdict_t          v,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] pc,
  input  logic              clr,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              trap_valid,
  output logic [7:0]        trap_code,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              pend,
  output logic [ADDR_W-1:0] pend_pc
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid  <= 1'b0;
      rsp_ok     <= 1'b0;
      trap_valid <= 1'b0;
      trap_code  <= '0;
      trap_addr  <= '0;
      pend       <= 1'b0;
      pend_pc    <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_ok     <= v.ok;
      trap_valid <= v.trap;
      if (v.trap) begin
        trap_code <= v.code;
        trap_addr <= v.sel_pc ? pc : addr;
      end
      if (v.set_pend) begin
        pend    <= 1'b1;
        pend_pc <= pc;
      end else if (clr) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mem_tag_guard.sv
module mem_tag_guard
  import tag_pkg::*;
#(
  parameter int ADDR_W      = 64,
  parameter int TAG_W       = 4,
  parameter int NUM_BLOCKS  = 64,
  parameter int BLOCK_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_nofault,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] req_pc,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              task_en,
  input  logic              page_chk,
  input  logic              page_ro,
  input  logic              precise_en,
  input  logic              clr_disrupt,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              trap_valid,
  output logic [7:0]        trap_code,
  output logic [ADDR_W-1:0] trap_addr,
  output logic              disrupt_pending,
  output logic [ADDR_W-1:0] disrupt_pc
);

  localparam int OFS_W = $clog2(BLOCK_BYTES);
  localparam int IDX_W = $clog2(NUM_BLOCKS);

  logic [IDX_W-1:0] blk_idx;
  logic [TAG_W-1:0] addr_tag;
  logic [TAG_W-1:0] mem_tag;
  logic [TAG_W-1:0] wr_tag;
  verdict_t         verdict;

  assign blk_idx  = req_addr[OFS_W +: IDX_W];
  assign addr_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign wr_tag   = verdict.wr_zero ? '0 : req_tag;

  tag_store #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .TAG_W      (TAG_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .rd_idx (blk_idx),
    .rd_tag (mem_tag),
    .wr_en  (verdict.wr_en),
    .wr_idx (blk_idx),
    .wr_tag (wr_tag)
  );

  tag_judge #(
    .TAG_W (TAG_W)
  ) u_judge (
    .valid      (req_valid),
    .op         (op_e'(req_op)),
    .nofault    (req_nofault),
    .task_en    (task_en),
    .page_chk   (page_chk),
    .page_ro    (page_ro),
    .precise_en (precise_en),
    .pend_now   (disrupt_pending),
    .clr        (clr_disrupt),
    .addr_tag   (addr_tag),
    .mem_tag    (mem_tag),
    .v          (verdict)
  );

  trap_report #(
    .ADDR_W (ADDR_W)
  ) u_report (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .v          (verdict),
    .addr       (req_addr),
    .pc         (req_pc),
    .clr        (clr_disrupt),
    .rsp_valid  (rsp_valid),
    .rsp_ok     (rsp_ok),
    .trap_valid (trap_valid),
    .trap_code  (trap_code),
    .trap_addr  (trap_addr),
    .pend       (disrupt_pending),
    .pend_pc    (disrupt_pc)
  );

endmodule

// File: rtl/mem_tag_guard_chk.sv
module mem_tag_guard_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              req_nofault,
  input logic              task_en,
  input logic              page_chk,
  input logic              page_ro,
  input logic              clr_disrupt,
  input logic              rsp_valid,
  input logic              rsp_ok,
  input logic              trap_valid,
  input logic [7:0]        trap_code,
  input logic [ADDR_W-1:0] trap_addr,
  input logic              disrupt_pending,
  input logic [ADDR_W-1:0] disrupt_pc
);

  assert_unchecked_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op[1] && !(task_en && page_chk)) |=> (rsp_ok && !trap_valid));

  assert_nofault_load_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd0 && req_nofault) |=> (rsp_ok && !trap_valid));

  assert_disabled_tagset_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd2 && !task_en) |=> (trap_valid && trap_code == 8'h0A && !rsp_ok));

  assert_ro_refused_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd2 && task_en && page_ro) |=> (!rsp_ok && !trap_valid));

  assert_blkinit_ok_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd3) |=> (rsp_ok && !trap_valid));

  assert_pend_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (disrupt_pending && !clr_disrupt) |=> (disrupt_pending && $stable(disrupt_pc)));

  assert_disrupt_latched_R5: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_code == 8'h7E) |-> (disrupt_pending && disrupt_pc == trap_addr && rsp_ok));

  assert_precise_denied_R6: assert property (@(posedge clk) disable iff (rst)
    (trap_valid && trap_code == 8'h1A) |-> !rsp_ok);

  assert_resp_follows_R12: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !trap_valid));

endmodule

bind mem_tag_guard mem_tag_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mem_tag_guard_bench.sv
module mem_tag_guard_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [1:0]  req_op;
  logic        req_nofault;
  logic [63:0] req_addr;
  logic [63:0] req_pc;
  logic [3:0]  req_tag;
  logic        task_en, page_chk, page_ro, precise_en, clr_disrupt;
  logic        rsp_valid, rsp_ok, trap_valid, disrupt_pending;
  logic [7:0]  trap_code;
  logic [63:0] trap_addr, disrupt_pc;

  int checks = 0;
  int failures = 0;

  // bench model state
  logic [3:0]  m_tag [64];
  logic        m_pend;
  logic [63:0] m_ppc;
  logic [7:0]  m_code;
  logic [63:0] m_taddr;

  always #10 clk = ~clk;

  mem_tag_guard u_mem_tag_guard (.*);

  task automatic chk(input logic ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [3:0] t, input int blk, input int off);
    logic [63:0] a;
    a = 64'h0000_1234_5678_0000;
    a[63:60] = t;
    a[11:6]  = blk[5:0];
    a[5:0]   = off[5:0];
    return a;
  endfunction

  function automatic logic is_wild(input logic [3:0] t);
    return (t == 4'h0) || (t == 4'hF);
  endfunction

  task automatic run(input logic [1:0] op, input logic [63:0] addr, input logic [63:0] pc,
                     input logic [3:0] wt, input logic nf, input logic ten, input logic pchk,
                     input logic pro, input logic pen, input logic clr, input string rq);
    logic [5:0] idx;
    logic mm, e_ok, e_trap;
    idx = addr[11:6];
    mm = ten && pchk && !is_wild(addr[63:60]) && !is_wild(m_tag[idx]) &&
         (addr[63:60] != m_tag[idx]);
    e_ok = 1'b0; e_trap = 1'b0;
    case (op)
      2'd0: if (mm && !nf) begin e_trap = 1; m_code = 8'h1A; m_taddr = addr; end
            else e_ok = 1;
      2'd1: if (mm && pen) begin e_trap = 1; m_code = 8'h1A; m_taddr = addr; end
            else begin
              e_ok = 1;
              if (mm && (!m_pend || clr)) begin
                e_trap = 1; m_code = 8'h7E; m_taddr = pc; m_pend = 1; m_ppc = pc;
              end else if (clr) m_pend = 0;
            end
      2'd2: if (!ten) begin e_trap = 1; m_code = 8'h0A; m_taddr = addr; end
            else if (!pro) begin e_ok = 1; m_tag[idx] = wt; end
      default: begin e_ok = 1; m_tag[idx] = 4'h0; end
    endcase
    if (op != 2'd1 && clr) m_pend = 0;
    if (op == 2'd1 && !(mm && !pen) && clr && !e_trap) m_pend = 0;
    req_valid = 1; req_op = op; req_addr = addr; req_pc = pc; req_tag = wt;
    req_nofault = nf; task_en = ten; page_chk = pchk; page_ro = pro;
    precise_en = pen; clr_disrupt = clr;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; clr_disrupt = 0;
    chk(rsp_valid == 1'b1, rq, "rsp_valid", 64'(rsp_valid), 64'd1);
    chk(rsp_ok == e_ok, rq, "rsp_ok", 64'(rsp_ok), 64'(e_ok));
    chk(trap_valid == e_trap, rq, "trap_valid", 64'(trap_valid), 64'(e_trap));
    chk(trap_code == m_code, rq, "trap_code", 64'(trap_code), 64'(m_code));
    chk(trap_addr == m_taddr, rq, "trap_addr", trap_addr, m_taddr);
    chk(disrupt_pending == m_pend, rq, "disrupt_pending", 64'(disrupt_pending), 64'(m_pend));
    chk(disrupt_pc == m_ppc, rq, "disrupt_pc", disrupt_pc, m_ppc);
  endtask

  task automatic idle(input string rq);
    req_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, rq, "idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk(trap_valid == 1'b0, rq, "idle trap_valid", 64'(trap_valid), 64'd0);
    chk(trap_code == m_code, rq, "held trap_code", 64'(trap_code), 64'(m_code));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 64; i++) m_tag[i] = 4'h0;
    m_pend = 0; m_ppc = '0; m_code = '0; m_taddr = '0;
    rst = 1; req_valid = 0; req_op = 0; req_nofault = 0; req_addr = '0; req_pc = '0;
    req_tag = 0; task_en = 0; page_chk = 0; page_ro = 0; precise_en = 0; clr_disrupt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R11: reset state
    chk(rsp_valid == 0 && trap_valid == 0 && disrupt_pending == 0 && trap_code == 0,
        "R11", "reset outputs", {rsp_valid, trap_valid, disrupt_pending}, 64'd0);
    run(2'd0, mk(4'h5, 3, 0), 64'h100, 0, 0, 1, 1, 0, 0, 0, "R11");
    // R1: tag one block, check offsets and neighbours
    run(2'd2, mk(4'h0, 3, 17), 64'h104, 4'h5, 0, 1, 1, 0, 0, 0, "R1");
    run(2'd0, mk(4'h5, 3, 63), 64'h108, 0, 0, 1, 1, 0, 0, 0, "R1");
    run(2'd0, mk(4'h6, 3, 63), 64'h10C, 0, 0, 1, 1, 0, 0, 0, "R1");
    run(2'd0, mk(4'h6, 4, 0), 64'h110, 0, 0, 1, 1, 0, 0, 0, "R1");
    run(2'd0, mk(4'h6, 2, 63), 64'h114, 0, 0, 1, 1, 0, 0, 0, "R1");
    // R6: load mismatch precise regardless of precise_en
    run(2'd0, mk(4'h9, 3, 8), 64'h118, 0, 0, 1, 1, 0, 1, 0, "R6");
    // R3: wildcards on both sides
    run(2'd0, mk(4'h0, 3, 0), 64'h11C, 0, 0, 1, 1, 0, 1, 0, "R3");
    run(2'd0, mk(4'hF, 3, 0), 64'h120, 0, 0, 1, 1, 0, 1, 0, "R3");
    run(2'd2, mk(4'h0, 5, 0), 64'h124, 4'hF, 0, 1, 1, 0, 0, 0, "R3");
    run(2'd1, mk(4'h7, 5, 0), 64'h128, 0, 0, 1, 1, 0, 1, 0, "R3");
    // R2: checking gated by both enables
    run(2'd0, mk(4'h6, 3, 0), 64'h12C, 0, 0, 1, 0, 0, 1, 0, "R2");
    run(2'd1, mk(4'h6, 3, 0), 64'h130, 0, 0, 0, 1, 0, 1, 0, "R2");
    // R4: precise store
    run(2'd1, mk(4'h6, 3, 4), 64'h134, 0, 0, 1, 1, 0, 1, 0, "R4");
    // R5: deferred store errors
    run(2'd1, mk(4'h6, 3, 4), 64'hAAA0, 0, 0, 1, 1, 0, 0, 0, "R5");
    run(2'd1, mk(4'h7, 3, 4), 64'hBBB0, 0, 0, 1, 1, 0, 0, 0, "R5");
    run(2'd1, mk(4'h8, 3, 4), 64'hCCC0, 0, 0, 1, 1, 0, 0, 1, "R5");
    run(2'd0, mk(4'h5, 3, 4), 64'h138, 0, 0, 1, 1, 0, 0, 1, "R5");
    run(2'd1, mk(4'h7, 3, 4), 64'hDDD0, 0, 0, 1, 1, 0, 0, 0, "R5");
    // R7: non-faulting load
    run(2'd0, mk(4'h9, 3, 0), 64'h13C, 0, 1, 1, 1, 0, 0, 0, "R7");
    // R8: tag-set with feature disabled, tag unchanged
    run(2'd2, mk(4'h0, 3, 0), 64'h140, 4'h9, 0, 0, 1, 0, 0, 0, "R8");
    run(2'd0, mk(4'h9, 3, 0), 64'h144, 0, 0, 1, 1, 0, 0, 0, "R8");
    // R10: read-only tag-set refused, tag unchanged
    run(2'd2, mk(4'h0, 3, 0), 64'h148, 4'h9, 0, 1, 1, 1, 0, 0, "R10");
    run(2'd0, mk(4'h9, 3, 0), 64'h14C, 0, 0, 1, 1, 0, 0, 0, "R10");
    // R9: block-init clears tag
    run(2'd3, mk(4'h0, 3, 0), 64'h150, 0, 0, 1, 1, 0, 0, 0, "R9");
    run(2'd0, mk(4'h9, 3, 0), 64'h154, 0, 0, 1, 1, 0, 0, 0, "R9");
    // R12: idle cycle quiet, codes held
    idle("R12");
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [1:0] op;
      logic [63:0] pc;
      op = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 9) < 4) op = 2'd0;
      pc = {32'h0, $urandom};
      run(op, mk(4'($urandom_range(0, 15)), $urandom_range(0, 7), $urandom_range(0, 63)), pc,
          4'($urandom_range(0, 15)), ($urandom_range(0, 7) == 0),
          ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0),
          ($urandom_range(0, 5) == 0), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 9) == 0), "R12");
      if ($urandom_range(0, 15) == 0) idle("R12");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule